// File: doc/BRIEF.md
# Multiplexed Bidirectional GPIO Port Controller

This block runs one 8-pin general-purpose port and decides, pin by pin, who drives each pad. A small register bus holds a latch for output data, a direction mask and a control word. The pad side is a bundle of output value, output enable and weak pull-up enable per pin, plus the raw pad levels coming back.

Three other owners can take pins away from plain GPIO. An external memory bus can claim the whole port as the upper address/data byte. A parallel slave port can claim the low three pins as control inputs. A capture/compare output can claim the top pin, with either push-pull or open-drain drive. Software reads pad levels through a two-flop synchronizer. Software reads the latch through a separate address.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset the direction register reads 0xFF (all inputs), the latch reads 0x00, the control word reads 0x02 (bus released, everything else off), and every pad output enable and pull-up enable is 0.
- R2: A write to address 0 (pin address) or address 1 (latch address) loads the latch, and a read of address 1 returns the latch.
- R3: A read of address 0 returns the pad levels through two flops: a pad change made before clock edge k is invisible after edge k and visible after edge k+1.
- R4: In GPIO ownership, direction bit 0 makes the pin an output (enable 1, value from the latch), and direction bit 1 makes it an input (enable 0). Direction is written at address 2.
- R5: The pull-up enable of pin i is 1 exactly when control bit 0 (global pull-up) is 1, direction bit i is 1, and control bit 1 (bus released) is 1.
- R6: When control bit 1 is 0, the external bus owns every pin: pad value equals the bus address byte, every enable equals the bus drive input, pull-ups are 0 and the direction register has no effect. The bus data output always mirrors the raw pad levels.
- R7: With the bus released and control bit 2 (slave mode) set, pins 0 to 2 have their output enables forced to 0 and the slave control output carries their synchronized levels. Otherwise the slave control output is 0.
- R8: With the bus released and control bit 4 (alternate select) set, pin 7 drives the peripheral output with enable 1 when control bit 3 (open-drain) is 0.
- R9: In the same mode with control bit 3 set, pin 7 holds value 0 and asserts its enable only while the peripheral output is 0.
- R10: Bus ownership overrides slave mode and the pin-7 peripheral: with all three requested, every pin follows R6.
- R11: The control word sits at address 3 with bits 0 to 4 as named above. Bits 7:5 read as 0 whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| bus_addr_hi_i | input | 8 | External bus high address/data byte to drive |
| bus_drive_i | input | 1 | External bus wants the port driven |
| bus_data_o | output | 8 | Raw pad levels returned to the bus |
| alt_out_i | input | 1 | Capture/compare output for pin 7 |
| psp_ctl_o | output | 3 | Synchronized slave-port control inputs |
| pad_in_i | input | 8 | Pad input levels |
| pad_out_o | output | 8 | Pad output values |
| pad_oe_o | output | 8 | Pad output enables |
| pad_pu_o | output | 8 | Pad weak pull-up enables |

## Verification
A write to the pin address and a change of pad levels can land in the same cycle. They use separate paths: the write data goes into the latch, and the read returns the sampled pads. The bench writes to address 0 on the same falling edge that it changes the pads. It then expects the latch read to show the written byte, and the pin read to show the new pad byte only after two edges. A second overlap sets bus mode, slave mode and open-drain together, and expects the bus to own every pin.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    ADDR_PIN  = 2'd0,
    ADDR_LAT  = 2'd1,
    ADDR_DIR  = 2'd2,
    ADDR_CTRL = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic alt_sel;
    logic od_en;
    logic slave_en;
    logic bus_off;
    logic pu_en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam logic [CTRL_W-1:0] CTRL_RST = 5'b00010;
endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [WIDTH-1:0] pin_sync_i,
  output logic [WIDTH-1:0] lat_o,
  output logic [WIDTH-1:0] dir_o,
  output ctrl_t            ctrl_o,
  output logic [WIDTH-1:0] rdata_o
);
  localparam int PAD_W = WIDTH - CTRL_W;

  logic [WIDTH-1:0] lat_q, dir_q;
  ctrl_t            ctrl_q;
  reg_addr_e        addr;

  assign addr = reg_addr_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q  <= '0;
      dir_q  <= '1;
      ctrl_q <= ctrl_t'(CTRL_RST);
    end else if (we_i) begin
      unique case (addr)
        ADDR_PIN, ADDR_LAT: lat_q  <= wdata_i;
        ADDR_DIR:           dir_q  <= wdata_i;
        ADDR_CTRL:          ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
        default:            ;
      endcase
    end
  end

  always_comb begin
    unique case (addr)
      ADDR_PIN:  rdata_o = pin_sync_i;
      ADDR_LAT:  rdata_o = lat_q;
      ADDR_DIR:  rdata_o = dir_q;
      ADDR_CTRL: rdata_o = {{PAD_W{1'b0}}, ctrl_q};
      default:   rdata_o = '0;
    endcase
  end

  assign lat_o  = lat_q;
  assign dir_o  = dir_q;
  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/gpio_port_pad_mux.sv
module gpio_port_pad_mux
  import gpio_port_pkg::*;
#(
  parameter int WIDTH    = 8,
  parameter int CTL_PINS = 3,
  parameter int ALT_PIN  = 7
) (
  input  logic [WIDTH-1:0] lat_i,
  input  logic [WIDTH-1:0] dir_i,
  input  ctrl_t            ctrl_i,
  input  logic [WIDTH-1:0] bus_addr_i,
  input  logic             bus_drive_i,
  input  logic             alt_out_i,
  output logic [WIDTH-1:0] pad_out_o,
  output logic [WIDTH-1:0] pad_oe_o,
  output logic [WIDTH-1:0] pad_pu_o
);
  logic bus_own;
  assign bus_own = ~ctrl_i.bus_off;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic gp_out, gp_oe;

    if (i == ALT_PIN) begin : g_alt
      // peripheral override; open-drain only pulls low
      assign gp_out = ctrl_i.alt_sel ? (alt_out_i & ~ctrl_i.od_en) : lat_i[i];
      assign gp_oe  = ctrl_i.alt_sel ? (~ctrl_i.od_en | ~alt_out_i) : ~dir_i[i];
    end else if (i < CTL_PINS) begin : g_ctl
      assign gp_out = lat_i[i];
      assign gp_oe  = ~dir_i[i] & ~ctrl_i.slave_en;
    end else begin : g_plain
      assign gp_out = lat_i[i];
      assign gp_oe  = ~dir_i[i];
    end

    assign pad_out_o[i] = bus_own ? bus_addr_i[i] : gp_out;
    assign pad_oe_o[i]  = bus_own ? bus_drive_i   : gp_oe;
    assign pad_pu_o[i]  = ctrl_i.pu_en & dir_i[i] & ~bus_own;
  end
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
  import gpio_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CTL_PINS    = 3,
  parameter int ALT_PIN     = 7
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic [1:0]          reg_addr_i,
  input  logic [WIDTH-1:0]    reg_wdata_i,
  output logic [WIDTH-1:0]    reg_rdata_o,
  input  logic [WIDTH-1:0]    bus_addr_hi_i,
  input  logic                bus_drive_i,
  output logic [WIDTH-1:0]    bus_data_o,
  input  logic                alt_out_i,
  output logic [CTL_PINS-1:0] psp_ctl_o,
  input  logic [WIDTH-1:0]    pad_in_i,
  output logic [WIDTH-1:0]    pad_out_o,
  output logic [WIDTH-1:0]    pad_oe_o,
  output logic [WIDTH-1:0]    pad_pu_o
);
  logic [WIDTH-1:0] pin_sync, lat, dir;
  ctrl_t            ctrl;

  gpio_port_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pad_in_i), .q_o(pin_sync)
  );

  gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .pin_sync_i(pin_sync), .lat_o(lat), .dir_o(dir),
    .ctrl_o(ctrl), .rdata_o(reg_rdata_o)
  );

  gpio_port_pad_mux #(.WIDTH(WIDTH), .CTL_PINS(CTL_PINS), .ALT_PIN(ALT_PIN)) u_mux (
    .lat_i(lat), .dir_i(dir), .ctrl_i(ctrl), .bus_addr_i(bus_addr_hi_i),
    .bus_drive_i(bus_drive_i), .alt_out_i(alt_out_i), .pad_out_o(pad_out_o),
    .pad_oe_o(pad_oe_o), .pad_pu_o(pad_pu_o)
  );

  assign bus_data_o = pad_in_i;
  assign psp_ctl_o  = (ctrl.slave_en & ctrl.bus_off) ? pin_sync[CTL_PINS-1:0] : '0;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_port_pkg::*;
#(
  parameter int WIDTH    = 8,
  parameter int CTL_PINS = 3,
  parameter int ALT_PIN  = 7
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                reg_we_i,
  input logic [1:0]          reg_addr_i,
  input logic [WIDTH-1:0]    reg_wdata_i,
  input logic [WIDTH-1:0]    bus_addr_hi_i,
  input logic                bus_drive_i,
  input logic                alt_out_i,
  input logic [CTL_PINS-1:0] psp_ctl_o,
  input logic [WIDTH-1:0]    pad_out_o,
  input logic [WIDTH-1:0]    pad_oe_o,
  input logic [WIDTH-1:0]    pad_pu_o,
  input logic [WIDTH-1:0]    lat,
  input logic [WIDTH-1:0]    dir,
  input ctrl_t               ctrl
);
  // R2
  latch_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i <= 2'd1) |=> lat == $past(reg_wdata_i));

  // R5
  pullup_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_pu_o != '0) |-> (ctrl.pu_en && ctrl.bus_off && (pad_pu_o & ~dir) == '0));

  // R6
  bus_own_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl.bus_off |-> (pad_out_o == bus_addr_hi_i && pad_oe_o == {WIDTH{bus_drive_i}}
                       && pad_pu_o == '0 && psp_ctl_o == '0));

  // R7
  slave_float_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.bus_off && ctrl.slave_en) |-> pad_oe_o[CTL_PINS-1:0] == '0);

  // R9
  open_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.bus_off && ctrl.alt_sel && ctrl.od_en) |->
      (!pad_out_o[ALT_PIN] && pad_oe_o[ALT_PIN] == !alt_out_i));

  // R8
  alt_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.bus_off && ctrl.alt_sel && !ctrl.od_en) |->
      (pad_out_o[ALT_PIN] == alt_out_i && pad_oe_o[ALT_PIN]));
endmodule

bind gpio_mux_port gpio_port_chk #(.WIDTH(WIDTH), .CTL_PINS(CTL_PINS), .ALT_PIN(ALT_PIN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .bus_addr_hi_i(bus_addr_hi_i), .bus_drive_i(bus_drive_i),
  .alt_out_i(alt_out_i), .psp_ctl_o(psp_ctl_o), .pad_out_o(pad_out_o),
  .pad_oe_o(pad_oe_o), .pad_pu_o(pad_pu_o), .lat(lat), .dir(dir), .ctrl(ctrl)
);

// File: tb/sim_gpio_mux_port.sv
module sim_gpio_mux_port;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [1:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic [7:0] bus_addr_hi_i = '0;
  logic       bus_drive_i = 1'b0;
  logic [7:0] bus_data_o;
  logic       alt_out_i = 1'b0;
  logic [2:0] psp_ctl_o;
  logic [7:0] pad_in_i = '0;
  logic [7:0] pad_out_o, pad_oe_o, pad_pu_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  gpio_mux_port u0 (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(2'd2, v); check("R1 dir", v, 8'hFF);
    rd(2'd1, v); check("R1 lat", v, 8'h00);
    rd(2'd3, v); check("R1 ctrl", v, 8'h02);
    check("R1 oe", pad_oe_o, 8'h00);
    check("R1 pu", pad_pu_o, 8'h00);
  endtask

  task automatic t_latch;
    logic [7:0] v;
    wr(2'd1, 8'hA5);
    rd(2'd1, v); check("R2 lat write", v, 8'hA5);
    // pin-address write coincides with a pad change
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = 2'd0; reg_wdata_i = 8'h3C; pad_in_i = 8'h81;
    @(negedge clk_i);
    reg_we_i = 1'b0;
    rd(2'd1, v); check("R2 pin-addr write", v, 8'h3C);
    rd(2'd0, v); check("R3 one edge", v, 8'h00);
    @(negedge clk_i);
    rd(2'd0, v); check("R3 two edges", v, 8'h81);
  endtask

  task automatic t_sync;
    logic [7:0] v;
    @(negedge clk_i); pad_in_i = 8'h5A;
    @(negedge clk_i);
    rd(2'd0, v); check("R3 stale", v, 8'h81);
    @(negedge clk_i);
    rd(2'd0, v); check("R3 fresh", v, 8'h5A);
  endtask

  task automatic t_dir;
    wr(2'd2, 8'h03);
    wr(2'd1, 8'hF0);
    #1;
    check("R4 oe", pad_oe_o, 8'hFC);
    check("R4 out", pad_out_o, 8'hF0);
  endtask

  task automatic t_pull;
    wr(2'd3, 8'h03);
    #1 check("R5 pu on", pad_pu_o, 8'h03);
    wr(2'd3, 8'h02);
    #1 check("R5 pu off", pad_pu_o, 8'h00);
  endtask

  task automatic t_bus;
    logic [7:0] v;
    bus_addr_hi_i = 8'h96; bus_drive_i = 1'b1; alt_out_i = 1'b1;
    wr(2'd3, 8'h1D);
    #1;
    check("R6 R10 out", pad_out_o, 8'h96);
    check("R6 R10 oe", pad_oe_o, 8'hFF);
    check("R6 pu", pad_pu_o, 8'h00);
    check("R10 psp", {5'd0, psp_ctl_o}, 8'h00);
    check("R6 bus data", bus_data_o, pad_in_i);
    bus_drive_i = 1'b0;
    #1 check("R6 oe released", pad_oe_o, 8'h00);
    rd(2'd3, v); check("R11 ctrl readback", v, 8'h1D);
  endtask

  task automatic t_slave;
    logic [7:0] v;
    wr(2'd3, 8'h06);
    wr(2'd2, 8'h00);
    wr(2'd1, 8'hFF);
    #1 check("R7 oe", pad_oe_o, 8'hF8);
    @(negedge clk_i); pad_in_i = 8'h05;
    @(negedge clk_i); @(negedge clk_i);
    check("R7 ctl", {5'd0, psp_ctl_o}, 8'h05);
    wr(2'd3, 8'h02);
    #1 check("R7 ctl off", {5'd0, psp_ctl_o}, 8'h00);
    wr(2'd3, 8'hFF);
    rd(2'd3, v); check("R11 upper bits", v, 8'h1F);
  endtask

  task automatic t_alt;
    wr(2'd2, 8'hFF);
    wr(2'd3, 8'h12);
    alt_out_i = 1'b1;
    #1 check("R8 high", {pad_out_o[7], pad_oe_o[7]}, 8'h03);
    alt_out_i = 1'b0;
    #1 check("R8 low", {pad_out_o[7], pad_oe_o[7]}, 8'h01);
    wr(2'd3, 8'h1A);
    alt_out_i = 1'b1;
    #1 check("R9 float", {pad_out_o[7], pad_oe_o[7]}, 8'h00);
    alt_out_i = 1'b0;
    #1 check("R9 pull low", {pad_out_o[7], pad_oe_o[7]}, 8'h01);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_latch();
    t_sync();
    t_dir();
    t_pull();
    t_bus();
    t_slave();
    t_alt();
    finish_run();
  end
endmodule